// File: doc/BRIEF.md
# Integer Compare Unit with Condition Field Bank

This block compares a 64-bit register operand against either a second register operand or a 16-bit immediate that is sign-extended to 64 bits. The compare is signed (two's complement) or logical (unsigned). The length bit selects a full-width compare or a compare of the low halves. The outcome is a 4-bit code that is stored in one of eight condition fields. A 3-bit index chosen by the issuing instruction picks the field.

Two configuration inputs set how the length bit is treated. One says whether the implementation supports 64-bit operation. The other marks an embedded variant. On a 64-bit implementation the length bit chooses the compare width. On a 32-bit implementation the compare is always done on 32 bits. A set length bit there is either rejected with an illegal-instruction pulse, on the embedded variant, or ignored with an invalid-form warning pulse. The summary-overflow bit of the result is copied from an input.

Top module: `cmp_cond_unit`

## Requirements
- R1: While reset is asserted (rstN low), and on the first clock after it, all condition fields read zero and illegalOut and badFormWarn are low.
- R2: With cfgWide=1 and lenBit=1, the compare uses all 64 bits of both operands.
- R3: With cfgWide=1 and lenBit=0, only bits 31:0 of each operand are compared. Before the compare they are sign-extended in signed mode and zero-extended in logical mode.
- R4: With cfgWide=0 and lenBit=0, the compare is the 32-bit compare of R3.
- R5: With cfgWide=0, lenBit=1 and cfgEmbedded=1, illegalOut is high for the one cycle after the strobe. No condition field changes, and badFormWarn stays low.
- R6: With cfgWide=0, lenBit=1 and cfgEmbedded=0, the 32-bit compare of R3 is done and written, and badFormWarn is high for the one cycle after the strobe.
- R7: signedMode=1 orders operands as two's-complement numbers. signedMode=0 orders them as unsigned numbers.
- R8: With useImm=1, the second operand is imm sign-extended to 64 bits, in both signed and logical mode. opB is then ignored.
- R9: The result nibble is {LT, GT, EQ, SO}, with bit 3 = LT and bit 0 = SO. Exactly one of LT, GT and EQ is set. SO equals soIn at the strobe.
- R10: A legal compare strobed with inValid writes condFields[4*k+3:4*k], where k = fieldIdx, at the next rising clock edge. The other seven fields keep their values.
- R11: In a cycle without inValid, no field changes, and illegalOut and badFormWarn are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Compare request strobe |
| opA | input | 64 | First operand (register value) |
| opB | input | 64 | Second register operand |
| useImm | input | 1 | Select the immediate as the second operand |
| imm | input | 16 | Immediate, sign-extended before use |
| signedMode | input | 1 | 1 = two's-complement order, 0 = unsigned order |
| lenBit | input | 1 | Length bit: 1 asks for a 64-bit compare |
| fieldIdx | input | 3 | Target condition field index |
| soIn | input | 1 | Summary-overflow value copied into the result |
| cfgWide | input | 1 | Implementation supports 64-bit operation |
| cfgEmbedded | input | 1 | Embedded variant: lenBit=1 on 32-bit is illegal |
| condFields | output | 32 | Eight 4-bit condition fields, field k at bits 4k+3:4k |
| illegalOut | output | 1 | Illegal-instruction pulse |
| badFormWarn | output | 1 | Invalid-form warning pulse |

## Verification
The bound checker watches several properties on every cycle. It checks that a legal strobe leaves exactly one of LT, GT and EQ set in the addressed field, with SO copied from soIn. It checks that the seven other fields never move, that an illegal request changes nothing, that idle cycles are quiet, and that the two pulses are never high together. Whether the chosen relation is correct depends on the operand values and on the width and sign mode. Only the bench shows that, by comparing every result with its own reference model. Its directed cases cover upper-half-only differences, the low-half sign boundary, the sign-extended immediate, and every field index.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

  // Strobes from control to datapath, valid for one request cycle.
  typedef struct packed {
    logic writeField;   // legal request: store the result nibble
    logic useWide;      // compare the full operand width
    logic raiseIllegal; // reject the request
    logic flagBadForm;  // length bit ignored on a narrow implementation
  } cmpStrobes_t;

  // Bit positions inside a result nibble.
  localparam int RES_LT = 3;
  localparam int RES_GT = 2;
  localparam int RES_EQ = 1;
  localparam int RES_SO = 0;
  localparam int RES_W  = 4;

endpackage

// File: rtl/cmp_cond_ctrl.sv
module cmp_cond_ctrl
  import cmp_cond_pkg::*;
(
  input  logic        inValid,
  input  logic        lenBit,
  input  logic        cfgWide,
  input  logic        cfgEmbedded,
  output cmpStrobes_t strobes
);

  logic narrowWithLen;

  always_comb begin
    narrowWithLen        = !cfgWide && lenBit;
    strobes              = '0;
    strobes.useWide      = cfgWide && lenBit;
    strobes.raiseIllegal = inValid && narrowWithLen && cfgEmbedded;
    strobes.flagBadForm  = inValid && narrowWithLen && !cfgEmbedded;
    strobes.writeField   = inValid && !(narrowWithLen && cfgEmbedded);
  end

endmodule

// File: rtl/cmp_cond_field_bank.sv
module cmp_cond_field_bank #(
  parameter int NUM_FIELDS = 8,
  parameter int NIB_W      = 4,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int BANK_W    = NUM_FIELDS * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [NIB_W-1:0]  wrNib,
  output logic [BANK_W-1:0] bankOut
);

  // One register per field; only the addressed field loads.
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    logic [NIB_W-1:0] fieldQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fieldQ <= '0;
      end else if (wrEn && (wrIdx == IDX_W'(g))) begin
        fieldQ <= wrNib;
      end
    end
    assign bankOut[g*NIB_W +: NIB_W] = fieldQ;
  end

endmodule

// File: rtl/cmp_cond_dp.sv
module cmp_cond_dp
  import cmp_cond_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int HALF_W     = 32,
  parameter int IMM_W      = 16,
  parameter int NUM_FIELDS = 8,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int BANK_W    = NUM_FIELDS * RES_W,
  localparam int EXT_W     = DATA_W - HALF_W,
  localparam int IMM_EXT_W = DATA_W - IMM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm,
  input  logic              signedMode,
  input  logic [IDX_W-1:0]  fieldIdx,
  input  logic              soIn,
  output logic [BANK_W-1:0] condFields,
  output logic              illegalOut,
  output logic              badFormWarn
);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] secondOp;
  logic [DATA_W-1:0] leftVal;
  logic [DATA_W-1:0] rightVal;
  logic [DATA_W-1:0] leftKey;
  logic [DATA_W-1:0] rightKey;
  logic              isLess;
  logic              isEqual;
  logic [RES_W-1:0]  resultNib;

  // Immediate is always sign-extended to the operand width.
  assign immExt   = {{IMM_EXT_W{imm[IMM_W-1]}}, imm};
  assign secondOp = useImm ? immExt : opB;

  // Narrow compare: extend the low half according to the sign mode.
  always_comb begin
    if (strobes.useWide) begin
      leftVal  = opA;
      rightVal = secondOp;
    end else begin
      leftVal  = {{EXT_W{signedMode & opA[HALF_W-1]}}, opA[HALF_W-1:0]};
      rightVal = {{EXT_W{signedMode & secondOp[HALF_W-1]}}, secondOp[HALF_W-1:0]};
    end
  end

  // Flipping the top bit in signed mode turns a signed order into an
  // unsigned one, so a single magnitude comparator serves both modes.
  assign leftKey  = {leftVal[DATA_W-1] ^ signedMode, leftVal[DATA_W-2:0]};
  assign rightKey = {rightVal[DATA_W-1] ^ signedMode, rightVal[DATA_W-2:0]};
  assign isLess   = leftKey < rightKey;
  assign isEqual  = leftKey == rightKey;

  always_comb begin
    resultNib         = '0;
    resultNib[RES_LT] = isLess;
    resultNib[RES_GT] = !isLess && !isEqual;
    resultNib[RES_EQ] = isEqual;
    resultNib[RES_SO] = soIn;
  end

  cmp_cond_field_bank #(
    .NUM_FIELDS(NUM_FIELDS),
    .NIB_W     (RES_W)
  ) u_bank (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobes.writeField),
    .wrIdx  (fieldIdx),
    .wrNib  (resultNib),
    .bankOut(condFields)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      illegalOut  <= 1'b0;
      badFormWarn <= 1'b0;
    end else begin
      illegalOut  <= strobes.raiseIllegal;
      badFormWarn <= strobes.flagBadForm;
    end
  end

endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit
  import cmp_cond_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int HALF_W     = 32,
  parameter int IMM_W      = 16,
  parameter int NUM_FIELDS = 8,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int BANK_W    = NUM_FIELDS * RES_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm,
  input  logic              signedMode,
  input  logic              lenBit,
  input  logic [IDX_W-1:0]  fieldIdx,
  input  logic              soIn,
  input  logic              cfgWide,
  input  logic              cfgEmbedded,
  output logic [BANK_W-1:0] condFields,
  output logic              illegalOut,
  output logic              badFormWarn
);

  cmpStrobes_t strobes;

  cmp_cond_ctrl u_ctrl (
    .inValid    (inValid),
    .lenBit     (lenBit),
    .cfgWide    (cfgWide),
    .cfgEmbedded(cfgEmbedded),
    .strobes    (strobes)
  );

  cmp_cond_dp #(
    .DATA_W    (DATA_W),
    .HALF_W    (HALF_W),
    .IMM_W     (IMM_W),
    .NUM_FIELDS(NUM_FIELDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opA        (opA),
    .opB        (opB),
    .useImm     (useImm),
    .imm        (imm),
    .signedMode (signedMode),
    .fieldIdx   (fieldIdx),
    .soIn       (soIn),
    .condFields (condFields),
    .illegalOut (illegalOut),
    .badFormWarn(badFormWarn)
  );

endmodule

// File: rtl/cmp_cond_chk.sv
module cmp_cond_chk #(
  parameter int NUM_FIELDS = 8,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int BANK_W    = NUM_FIELDS * 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              lenBit,
  input logic              cfgWide,
  input logic              cfgEmbedded,
  input logic              soIn,
  input logic [IDX_W-1:0]  fieldIdx,
  input logic [BANK_W-1:0] condFields,
  input logic              illegalOut,
  input logic              badFormWarn
);

  localparam logic [BANK_W-1:0] NIB_MASK = BANK_W'(4'hF);

  logic [IDX_W-1:0]  prevIdx;
  logic [3:0]        curNib;
  logic [BANK_W-1:0] otherMask;
  logic              rejectNow;

  always_ff @(posedge clk) begin
    if (!rstN) prevIdx <= '0;
    else       prevIdx <= fieldIdx;
  end

  assign curNib    = condFields[{prevIdx, 2'b00} +: 4];
  assign otherMask = ~(NIB_MASK << {prevIdx, 2'b00});
  assign rejectNow = !cfgWide && lenBit && cfgEmbedded;

  // R9: one relation bit set, SO copied.
  a_r9_one_relation: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !rejectNow |=> ($countones(curNib[3:1]) == 1) && (curNib[0] == $past(soIn)));

  // R10: untouched fields hold.
  a_r10_others_hold: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((condFields ^ $past(condFields)) & otherMask) == '0);

  // R5: rejected request raises illegal and writes nothing.
  a_r5_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    inValid && rejectNow |=> illegalOut && !badFormWarn && $stable(condFields));

  // R6: ignored length bit raises the warning.
  a_r6_warn_pulse: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !cfgWide && lenBit && !cfgEmbedded |=> badFormWarn && !illegalOut);

  // R11: idle cycles are quiet.
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(condFields) && !illegalOut && !badFormWarn);

  // R5, R6: the two pulses are exclusive.
  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(illegalOut && badFormWarn));

endmodule

bind cmp_cond_unit cmp_cond_chk #(.NUM_FIELDS(NUM_FIELDS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .lenBit     (lenBit),
  .cfgWide    (cfgWide),
  .cfgEmbedded(cfgEmbedded),
  .soIn       (soIn),
  .fieldIdx   (fieldIdx),
  .condFields (condFields),
  .illegalOut (illegalOut),
  .badFormWarn(badFormWarn)
);

// File: tb/cmp_cond_unit_tb.sv
`timescale 1ns/1ps
module cmp_cond_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] opA, opB;
  logic        useImm;
  logic [15:0] imm;
  logic        signedMode, lenBit, soIn, cfgWide, cfgEmbedded;
  logic [2:0]  fieldIdx;
  logic [31:0] condFields;
  logic        illegalOut, badFormWarn;

  int          errCount = 0;
  int          chkCount = 0;
  logic [31:0] expFields;

  always #5 clk = ~clk;

  cmp_cond_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .useImm(useImm), .imm(imm), .signedMode(signedMode), .lenBit(lenBit),
    .fieldIdx(fieldIdx), .soIn(soIn), .cfgWide(cfgWide), .cfgEmbedded(cfgEmbedded),
    .condFields(condFields), .illegalOut(illegalOut), .badFormWarn(badFormWarn)
  );

  // Reference nibble {LT,GT,EQ,SO} built from the requirements.
  function automatic logic [3:0] refNib(input logic [63:0] a, input logic [63:0] b,
                                        input logic sgn, input logic narrow,
                                        input logic so);
    logic [63:0] x, y;
    logic lt, gt, eq;
    if (narrow) begin
      x = sgn ? {{32{a[31]}}, a[31:0]} : {32'd0, a[31:0]};
      y = sgn ? {{32{b[31]}}, b[31:0]} : {32'd0, b[31:0]};
    end else begin
      x = a;
      y = b;
    end
    eq = (x == y);
    lt = sgn ? ($signed(x) < $signed(y)) : (x < y);
    gt = !eq && !lt;
    return {lt, gt, eq, so};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic doOp(input string tag, input logic [63:0] a, input logic [63:0] b,
                      input logic ui, input logic [15:0] im, input logic sgn,
                      input logic len, input logic [2:0] idx, input logic wide,
                      input logic emb, input logic so);
    logic [63:0] second;
    logic expIll, expWarn;
    opA = a; opB = b; useImm = ui; imm = im; signedMode = sgn; lenBit = len;
    fieldIdx = idx; cfgWide = wide; cfgEmbedded = emb; soIn = so; inValid = 1'b1;
    second  = ui ? {{48{im[15]}}, im} : b;
    expIll  = !wide && len && emb;
    expWarn = !wide && len && !emb;
    if (!expIll)
      expFields[idx*4 +: 4] = refNib(a, second, sgn, !(wide && len), so);
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " fields"}, condFields, expFields);
    check({tag, " illegal"}, {31'd0, illegalOut}, {31'd0, expIll});
    check({tag, " warn"}, {31'd0, badFormWarn}, {31'd0, expWarn});
  endtask

  initial begin : watchdog
    #2_000_000;
    errCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount + 1);
    $finish;
  end

  initial begin : stim
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd1234);
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0; useImm = 1'b0; imm = '0;
    signedMode = 1'b0; lenBit = 1'b0; fieldIdx = '0; soIn = 1'b0;
    cfgWide = 1'b1; cfgEmbedded = 1'b0; expFields = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 fields", condFields, 32'd0);
    check("R1 flags", {30'd0, illegalOut, badFormWarn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", condFields, 32'd0);

    // R2 / R7: wide signed vs logical
    doOp("R2 R7 wide signed -1<1", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 1, 1, 3'd0, 1, 0, 0);
    doOp("R2 R7 wide logical max>1", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 1, 3'd1, 1, 0, 0);
    // R2 / R3: difference only in the upper half
    doOp("R2 upper half differs", 64'h1_0000_0005, 64'd5, 0, 0, 0, 1, 3'd2, 1, 0, 1);
    doOp("R3 upper half ignored", 64'h1_0000_0005, 64'd5, 0, 0, 0, 0, 3'd3, 1, 0, 0);
    // R3 / R7: low-half sign boundary
    doOp("R3 R7 narrow signed", 64'h0000_0000_8000_0000, 64'd1, 0, 0, 1, 0, 3'd4, 1, 0, 0);
    doOp("R3 R7 narrow logical", 64'h0000_0000_8000_0000, 64'd1, 0, 0, 0, 0, 3'd5, 1, 0, 0);
    // R4: narrow implementation
    doOp("R4 narrow impl", 64'hAB00_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, 0, 0, 1, 0, 3'd6, 0, 0, 1);
    // R6: length bit ignored with warning
    doOp("R6 len ignored", 64'h1_0000_0005, 64'd5, 0, 0, 0, 1, 3'd7, 0, 0, 0);
    // R5: embedded variant rejects
    doOp("R5 illegal", 64'd1, 64'd2, 0, 0, 1, 1, 3'd0, 0, 1, 1);
    // R8: immediate is sign-extended in both modes
    doOp("R8 imm signed eq", 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1, 16'hFFFF, 1, 1, 3'd1, 1, 0, 0);
    doOp("R8 imm logical eq", 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 1, 16'hFFFF, 0, 1, 3'd2, 1, 0, 0);
    doOp("R8 imm logical lt", 64'h0000_0000_0000_FFFF, 64'hFFFF, 1, 16'hFFFF, 0, 1, 3'd3, 1, 0, 0);
    // R9 / R10: every field, SO copied
    for (int k = 0; k < 8; k++)
      doOp("R9 R10 field sweep", 64'(k), 64'd3, 0, 0, 1, 1, 3'(k), 1, 0, k[0]);

    // R11: idle cycles with junk on inputs
    opA = 64'hDEAD; opB = 64'hBEEF; fieldIdx = 3'd5; lenBit = 1'b1; cfgWide = 1'b0; cfgEmbedded = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 idle fields", condFields, expFields);
    check("R11 idle flags", {30'd0, illegalOut, badFormWarn}, 32'd0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      logic [3:0]  pick;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      pick = 4'($urandom);
      if (pick[1:0] == 2'd0) rb = ra;
      else if (pick[1:0] == 2'd1) rb = {~ra[63:32], ra[31:0]};
      doOp("R2 R3 R7 R8 R10 random", ra, rb, pick[2], 16'($urandom), 1'($urandom),
           1'($urandom), 3'($urandom), pick[3] | 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule